// File: doc/BRIEF.md
# Accumulator-to-Word Store Converter

This block turns a 40-bit signed accumulator value into the 16-bit 1.15 fractional word that gets written to data memory. The kept word comes from the accumulator's upper word, bits 31:16. The lower 16 bits are either dropped or used to round the kept part. Rounding can be conventional (biased, where a half always rounds up) or convergent (unbiased, where an exact half rounds to the even result).

After rounding, an optional write-saturation stage clamps the word to the 1.15 range when the rounded value no longer fits in it. The clamp acts only on the value being stored. The accumulator that feeds the block is only read and never written back.

The conversion is combinational. A parameter adds one output register stage, which is on by default. Choosing which accumulator feeds the block and performing the memory write are left to the surrounding logic.

Top module: `acc_store_conv`

## Requirements
- R1: With `REG_OUT`=1, `store_word` is 16'h0000 while `rst_n` is low.
- R2: With `rnd_sel`=2'b00 (truncate) and no clamp, `store_word` equals `acc_in[31:16]`, and the low 16 bits have no effect.
- R3: With `rnd_sel`=2'b01 (conventional), the value `acc_in[39:16]` is incremented by 1 whenever `acc_in[15]` is 1. It is left unchanged otherwise.
- R4: With `rnd_sel`=2'b10 (convergent), rounding is the same as in R3, except when `acc_in[15:0]` is exactly 16'h8000. In that case the value is incremented only if `acc_in[16]` is 1, so the kept result is even.
- R5: With `sat_en`=0, `store_word` is bits 15:0 of the rounded 24-bit value `acc_in[39:16]` (plus any increment). The result wraps modulo 2^24 and is never clamped.
- R6: With `sat_en`=1, if bits 23:15 of the rounded 24-bit value are not all equal, `store_word` is 16'h7FFF when `acc_in[39]` is 0 and 16'h8000 when `acc_in[39]` is 1.
- R7: With `sat_en`=1 and those bits all equal, `store_word` is the same as with `sat_en`=0.
- R8: With `REG_OUT`=1, `store_word` reflects the inputs sampled at the previous rising edge of `clk`, a latency of one cycle.
- R9: `rnd_sel`=2'b11 behaves exactly like truncation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| acc_in | input | 40 | Signed accumulator value, read only |
| rnd_sel | input | 2 | 00 truncate, 01 conventional, 10 convergent, 11 truncate |
| sat_en | input | 1 | 1 enables clamping of the stored word |
| store_word | output | 16 | 1.15 word to be written to memory |

## Verification
Directed vectors put the low half at 16'h7FFF, 16'h8000 and 16'h8001, with both parities of the kept LSB. These cases separate conventional rounding from convergent rounding, and show whether the even/odd rule looks at the right bit. Vectors around 32'h7FFF_8000 and the full-scale 40-bit extremes show:
- whether the clamp tests the rounded value rather than the raw one;
- whether the limit follows the accumulator's sign when the 24-bit sum wraps.

Seeded random accumulators in all modes, with saturation on and off, check the general arithmetic against a floor-division reference model. A held-input step checks the one-cycle latency.

// File: rtl/acc_store_pkg.sv
package acc_store_pkg;

  typedef enum logic [1:0] {
    RM_TRUNC = 2'b00,
    RM_CONV  = 2'b01,
    RM_CNVG  = 2'b10,
    RM_RSVD  = 2'b11
  } rnd_mode_e;

  // Decide whether the kept part gets +1.
  // half:    the most significant dropped bit
  // sticky:  OR of all dropped bits below it
  // kept_lsb: least significant kept bit
  function automatic logic round_inc(input rnd_mode_e mode,
                                     input logic half,
                                     input logic sticky,
                                     input logic kept_lsb);
    logic inc;
    case (mode)
      RM_CONV: inc = half;
      RM_CNVG: inc = half & (sticky | kept_lsb);
      default: inc = 1'b0;
    endcase
    return inc;
  endfunction

  // True when a field of sign-copy bits disagrees.
  function automatic logic sign_field_broken(input logic all_one, input logic all_zero);
    return !(all_one || all_zero);
  endfunction

endpackage

// File: rtl/store_rounder.sv
module store_rounder
  import acc_store_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int DROP_W = 16,
  localparam int HI_W  = ACC_W - DROP_W
) (
  input  logic [ACC_W-1:0] acc,
  input  rnd_mode_e        mode,
  output logic [HI_W-1:0]  rnd_hi,
  output logic             inc,
  output logic             tie
);

  logic half;
  logic sticky;
  logic kept_lsb;

  assign half     = acc[DROP_W-1];
  assign sticky   = |acc[DROP_W-2:0];
  assign kept_lsb = acc[DROP_W];
  assign tie      = half & ~sticky;

  always_comb begin
    inc    = round_inc(mode, half, sticky, kept_lsb);
    rnd_hi = acc[ACC_W-1:DROP_W] + HI_W'(inc);
  end

endmodule

// File: rtl/store_saturator.sv
module store_saturator
  import acc_store_pkg::*;
#(
  parameter int HI_W  = 24,
  parameter int OUT_W = 16,
  localparam int CHK_W = HI_W - OUT_W + 1
) (
  input  logic [HI_W-1:0]  rnd_hi,
  input  logic             src_sign,
  input  logic             sat_en,
  output logic [OUT_W-1:0] word,
  output logic             clamp
);

  logic [CHK_W-1:0] chk;
  logic             out_of_range;
  logic [OUT_W-1:0] lim_pos;
  logic [OUT_W-1:0] lim_neg;

  assign chk          = rnd_hi[HI_W-1:OUT_W-1];
  assign out_of_range = sign_field_broken(&chk, ~|chk);
  assign lim_pos      = {1'b0, {(OUT_W-1){1'b1}}};
  assign lim_neg      = {1'b1, {(OUT_W-1){1'b0}}};
  assign clamp        = sat_en & out_of_range;

  always_comb begin
    if (clamp) word = src_sign ? lim_neg : lim_pos;
    else       word = rnd_hi[OUT_W-1:0];
  end

endmodule

// File: rtl/acc_store_conv.sv
module acc_store_conv
  import acc_store_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int DROP_W  = 16,
  parameter int OUT_W   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [1:0]       rnd_sel,
  input  logic             sat_en,
  output logic [OUT_W-1:0] store_word
);

  localparam int HI_W = ACC_W - DROP_W;

  rnd_mode_e        mode;
  logic [HI_W-1:0]  rnd_hi;
  logic             rnd_inc;
  logic             rnd_tie;
  logic [OUT_W-1:0] comb_word;
  logic             clamp_hit;

  assign mode = rnd_mode_e'(rnd_sel);

  store_rounder #(.ACC_W(ACC_W), .DROP_W(DROP_W)) u_rnd (
    .acc    (acc_in),
    .mode   (mode),
    .rnd_hi (rnd_hi),
    .inc    (rnd_inc),
    .tie    (rnd_tie)
  );

  store_saturator #(.HI_W(HI_W), .OUT_W(OUT_W)) u_sat (
    .rnd_hi   (rnd_hi),
    .src_sign (acc_in[ACC_W-1]),
    .sat_en   (sat_en),
    .word     (comb_word),
    .clamp    (clamp_hit)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) store_word <= '0;
        else        store_word <= comb_word;
      end

      assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> store_word == $past(comb_word));
    end else begin : g_comb
      assign store_word = comb_word;
    end
  endgenerate

  // Rounding only ever adds 0 or 1 to the kept part (R3).
  assert_round_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_hi == acc_in[ACC_W-1:DROP_W]) || (rnd_hi == acc_in[ACC_W-1:DROP_W] + HI_W'(1)));

  // An exact half in convergent mode always leaves an even result (R4).
  assert_tie_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RM_CNVG && rnd_tie) |-> !rnd_hi[0]);

  // Truncating modes pass the upper word through unchanged (R2).
  assert_trunc_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == RM_TRUNC || mode == RM_RSVD) && !clamp_hit)
      |-> comb_word == acc_in[DROP_W+OUT_W-1:DROP_W]);

  // Without the enable nothing clamps (R5).
  assert_no_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sat_en |-> (!clamp_hit && comb_word == rnd_hi[OUT_W-1:0]));

  // A clamped word is one of the two limits and follows the source sign (R6).
  assert_clamp_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_hit |-> ($countones(comb_word ^ {OUT_W{acc_in[ACC_W-1]}}) == OUT_W - 1
                   && comb_word[OUT_W-1] == acc_in[ACC_W-1]));

endmodule

// File: tb/tb_acc_store_conv.sv
module tb_acc_store_conv;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] acc_in = '0;
  logic [1:0]  rnd_sel = '0;
  logic        sat_en = 1'b0;
  logic [15:0] store_word;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_store_conv dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_in     (acc_in),
    .rnd_sel    (rnd_sel),
    .sat_en     (sat_en),
    .store_word (store_word)
  );

  // Reference: floor-divide by 2^16, adjust by remainder, wrap to 24 bits, clamp.
  function automatic longint ref_kept(logic [39:0] a, logic [1:0] m);
    longint sv;
    longint q;
    longint r;
    sv = $signed({{24{a[39]}}, a});
    q  = sv >>> 16;
    r  = sv & 64'hFFFF;
    if (m == 2'b01 && r >= 32768) q = q + 1;
    if (m == 2'b10 && (r > 32768 || (r == 32768 && (q & 1) == 1))) q = q + 1;
    return q;
  endfunction

  function automatic bit ref_oor(logic [39:0] a, logic [1:0] m);
    longint q;
    logic [23:0] h;
    longint hs;
    q  = ref_kept(a, m);
    h  = q[23:0];
    hs = $signed({{40{h[23]}}, h});
    return (hs > 32767) || (hs < -32768);
  endfunction

  function automatic logic [15:0] ref_word(logic [39:0] a, logic [1:0] m, logic s);
    longint q;
    q = ref_kept(a, m);
    if (s && ref_oor(a, m)) return a[39] ? 16'h8000 : 16'h7FFF;
    return q[15:0];
  endfunction

  function automatic string tag_of(logic [39:0] a, logic [1:0] m, logic s);
    if (s && ref_oor(a, m)) return "R6";
    if (s)                  return "R7";
    if (m == 2'b11)         return "R9";
    if (m == 2'b01)         return "R3";
    if (m == 2'b10)         return "R4";
    return "R2";
  endfunction

  task automatic compare(string tag, logic [15:0] exp_w);
    n_vec++;
    if (store_word !== exp_w) begin
      n_bad++;
      $display("FAIL %s: acc=%h mode=%0d sat=%0b got %h expected %h",
               tag, acc_in, rnd_sel, sat_en, store_word, exp_w);
    end
  endtask

  // Drive at a falling edge, then sample at the next falling edge, one rising edge later.
  task automatic apply(logic [39:0] a, logic [1:0] m, logic s, string tag);
    @(negedge clk);
    acc_in = a; rnd_sel = m; sat_en = s;
    @(negedge clk);
    compare(tag, ref_word(a, m, s));
  endtask

  task automatic apply_auto(logic [39:0] a, logic [1:0] m, logic s);
    apply(a, m, s, tag_of(a, m, s));
  endtask

  initial begin
    int seed;
    logic [15:0] prev;
    seed = 32'd20240611;
    void'($urandom(seed));

    // R1: reset value
    acc_in = 40'h00_1234_FFFF; rnd_sel = 2'b01;
    repeat (2) @(negedge clk);
    compare("R1", 16'h0000);
    rst_n = 1'b1;

    // R2 truncation ignores low word
    apply(40'h00_1234_FFFF, 2'b00, 1'b0, "R2");
    apply(40'hFF_8001_8000, 2'b00, 1'b1, "R2");
    // R3 conventional around half
    apply(40'h00_1234_7FFF, 2'b01, 1'b0, "R3");
    apply(40'h00_1234_8000, 2'b01, 1'b0, "R3");
    apply(40'h00_1235_8000, 2'b01, 1'b0, "R3");
    apply(40'hFF_FFFF_8000, 2'b01, 1'b0, "R3");
    // R4 convergent ties and near-ties
    apply(40'h00_1234_8000, 2'b10, 1'b0, "R4");
    apply(40'h00_1235_8000, 2'b10, 1'b0, "R4");
    apply(40'h00_1234_8001, 2'b10, 1'b0, "R4");
    apply(40'h00_1235_7FFF, 2'b10, 1'b0, "R4");
    apply(40'hFF_FFFF_8000, 2'b10, 1'b0, "R4");
    // R5 wrap without clamp
    apply(40'h00_7FFF_8000, 2'b01, 1'b0, "R5");
    apply(40'h7F_FFFF_FFFF, 2'b01, 1'b0, "R5");
    // R6 clamp limits and sign choice, including the wrapped sum
    apply(40'h00_7FFF_8000, 2'b01, 1'b1, "R6");
    apply(40'h00_8000_0000, 2'b00, 1'b1, "R6");
    apply(40'hFF_7FFF_FFFF, 2'b00, 1'b1, "R6");
    apply(40'h80_0000_0000, 2'b10, 1'b1, "R6");
    apply(40'h7F_FFFF_FFFF, 2'b01, 1'b1, "R6");
    // R7 in-range with clamp enabled
    apply(40'h00_7FFF_7FFF, 2'b01, 1'b1, "R7");
    apply(40'hFF_8000_0000, 2'b10, 1'b1, "R7");
    apply(40'hFF_FFFF_FFFF, 2'b01, 1'b1, "R7");
    // R9 reserved code truncates
    apply(40'h00_1234_FFFF, 2'b11, 1'b0, "R9");
    apply(40'h00_1235_8000, 2'b11, 1'b0, "R9");

    // R8: the new value is not visible before the rising edge, and is visible after it
    @(negedge clk);
    prev = store_word;
    acc_in = 40'h00_0ABC_0000; rnd_sel = 2'b00; sat_en = 1'b0;
    #1;
    compare("R8", prev);
    @(negedge clk);
    compare("R8", 16'h0ABC);

    for (int i = 0; i < 3000; i++) begin
      logic [39:0] a;
      logic [2:0]  pick;
      a    = {$urandom(), $urandom()};
      pick = 3'($urandom_range(0, 5));
      if (pick == 3'd1) a[15:0] = 16'h8000;
      if (pick == 3'd2) a[39:31] = {9{a[39]}};
      if (pick == 3'd3) a[15:0] = 16'h7FFF;
      apply_auto(a, 2'($urandom()), 1'($urandom()));
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule